// File: doc/BRIEF.md
# Segmented Real-Mode Address Former with Bit-20 Gate

This block turns a 16-bit segment and a 16-bit offset into a physical byte address for a 24-line memory bus. The segment is scaled by sixteen (four zero bits appended) and the offset is added to it. The result can be as large as 10_FFEFh, so the sum carries into bit 20.

A gate-enable input decides whether that bit 20 reaches the bus. With the gate closed, bit 20 is held low. Any address at or above 1 MB then folds back to the bottom of memory, as it would on a 20-line machine, and segment FFFFh behaves as segment -1. With the gate open, the carry passes through. Segment FFFFh then reaches the first 64 KB minus 16 bytes above 1 MB.

A one-cycle request strobe captures the segment, the offset and the gate state. The formed address appears on the bus one clock later, together with a one-cycle valid pulse. It holds there until the next strobe.

Top module: `rma_addr_gen`

## Requirements
- R1: After reset, `bus_addr` is 000000h and `addr_valid` is 0.
- R2: `addr_valid` is 1 in exactly the cycle after each clock edge at which `req` was 1, and 0 after any edge at which `req` was 0.
- R3: With `gate_en` = 1 at the strobe, `bus_addr` equals segment*16 + offset, including bit 20. For example, FFFF:0010 gives 100000h and FFFF:FFFF gives 10FFEFh.
- R4: With `gate_en` = 0 at the strobe, bit 20 of `bus_addr` is 0 and bits 19..0 equal those of segment*16 + offset. For example, FFFF:0010 gives 000000h and FFFF:FFFF gives 00FFEFh.
- R5: Bits 23..21 of `bus_addr` are always 0.
- R6: While `req` is 0, `bus_addr` keeps its value, whatever `seg`, `off` or `gate_en` do.
- R7: `gate_en` is taken only at the strobe edge. A change of `gate_en` after that edge does not alter the registered address.
- R8: A sum below 100000h comes out the same whether the gate is open or closed. For example, FFFF:000F gives 0FFFFFh in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe: capture the operands at this edge |
| seg | input | 16 | Segment value |
| off | input | 16 | Offset value |
| gate_en | input | 1 | 1 lets the bit-20 carry onto the bus, 0 forces bit 20 low |
| bus_addr | output | 24 | Registered physical address |
| addr_valid | output | 1 | One-cycle pulse marking a freshly formed address |

## Verification
The hardest case to reach from the ports is a carry into bit 20 that the gate removes. Only segment/offset pairs whose sum reaches 1 MB produce that carry, and it shows on the bus only as a missing bit. The bench drives the pairs right at the fold: FFFF:000F, FFFF:0010 and FFFF:FFFF, plus an interior pair, F800:8000. It drives each pair with the gate closed and again with the gate open. It also toggles the gate and the operands on the cycles after a strobe, to show that they have no effect on the held address.

// File: rtl/rma_pkg.sv
`timescale 1ns/1ps
package rma_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int BUS_W     = 24;
  localparam int GATE_BIT  = 20;
  // the scaled segment is the wider operand; one extra bit holds the carry
  localparam int SUM_W = ((SEG_W + SEG_SHIFT) > OFF_W ? (SEG_W + SEG_SHIFT) : OFF_W) + 1;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic             gate;
  } rma_req_t;
endpackage

// File: rtl/rma_seg_adder.sv
`timescale 1ns/1ps
module rma_seg_adder #(
  parameter int SEG_W     = rma_pkg::SEG_W,
  parameter int OFF_W     = rma_pkg::OFF_W,
  parameter int SEG_SHIFT = rma_pkg::SEG_SHIFT,
  parameter int SUM_W     = rma_pkg::SUM_W
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [SUM_W-1:0] sum,
  output logic             carry_top
);
  // scaled segment plus offset, widened to hold the top carry
  function automatic logic [SUM_W-1:0] linear_of(input logic [SEG_W-1:0] s,
                                                 input logic [OFF_W-1:0] o);
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] disp;
    base = SUM_W'({s, {SEG_SHIFT{1'b0}}});
    disp = SUM_W'(o);
    return base + disp;
  endfunction

  assign sum       = linear_of(seg, off);
  assign carry_top = sum[SUM_W-1];
endmodule

// File: rtl/rma_gate.sv
`timescale 1ns/1ps
module rma_gate #(
  parameter int SUM_W    = rma_pkg::SUM_W,
  parameter int BUS_W    = rma_pkg::BUS_W,
  parameter int GATE_BIT = rma_pkg::GATE_BIT
) (
  input  logic [SUM_W-1:0] sum,
  input  logic             gate_en,
  output logic [BUS_W-1:0] bus_next
);
  genvar i;
  generate
    for (i = 0; i < BUS_W; i++) begin : g_line
      if (i == GATE_BIT && i < SUM_W) begin : g_masked
        assign bus_next[i] = sum[i] & gate_en;
      end else if (i < SUM_W) begin : g_pass
        assign bus_next[i] = sum[i];
      end else begin : g_zero
        assign bus_next[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/rma_addr_reg.sv
`timescale 1ns/1ps
module rma_addr_reg #(
  parameter int BUS_W = rma_pkg::BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] d,
  output logic [BUS_W-1:0] q,
  output logic             valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end

  // R2: valid follows the strobe by one cycle
  a_r2_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !valid);
  // R6: no strobe, no change
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/rma_addr_gen.sv
`timescale 1ns/1ps
module rma_addr_gen #(
  parameter int SEG_W     = rma_pkg::SEG_W,
  parameter int OFF_W     = rma_pkg::OFF_W,
  parameter int SEG_SHIFT = rma_pkg::SEG_SHIFT,
  parameter int BUS_W     = rma_pkg::BUS_W,
  parameter int GATE_BIT  = rma_pkg::GATE_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             gate_en,
  output logic [BUS_W-1:0] bus_addr,
  output logic             addr_valid
);
  localparam int SUM_W = ((SEG_W + SEG_SHIFT) > OFF_W ? (SEG_W + SEG_SHIFT) : OFF_W) + 1;

  logic [SUM_W-1:0] sum;
  logic             carry_top;
  logic [BUS_W-1:0] bus_next;
  // named events for the checks below
  logic             wrap_dropped;
  logic             wrap_passed;

  rma_seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .SUM_W(SUM_W)) u_add (
    .seg(seg), .off(off), .sum(sum), .carry_top(carry_top));

  rma_gate #(.SUM_W(SUM_W), .BUS_W(BUS_W), .GATE_BIT(GATE_BIT)) u_gate (
    .sum(sum), .gate_en(gate_en), .bus_next(bus_next));

  rma_addr_reg #(.BUS_W(BUS_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(req), .d(bus_next),
    .q(bus_addr), .valid(addr_valid));

  assign wrap_dropped = req & carry_top & ~gate_en;
  assign wrap_passed  = req & carry_top &  gate_en;

  // R5: the lines above the carry bit never rise
  a_r5_high_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[BUS_W-1:GATE_BIT+1] == '0);
  // R4: a dropped carry leaves bit 20 low, low bits from the adder
  a_r4_carry_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dropped |=> (!bus_addr[GATE_BIT] &&
                      bus_addr[GATE_BIT-1:0] == $past(sum[GATE_BIT-1:0])));
  // R3: an open gate lets the carry through
  a_r3_carry_passed: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_passed |=> bus_addr[GATE_BIT]);
  // R8: without a carry the gate makes no difference
  a_r8_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !carry_top) |=> (bus_addr[GATE_BIT:0] == $past(sum[GATE_BIT:0])));
endmodule

// File: tb/rma_addr_gen_bench.sv
`timescale 1ns/1ps
module rma_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] seg = '0;
  logic [15:0] off = '0;
  logic        gate_en = 1'b0;
  logic [23:0] bus_addr;
  logic        addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rma_addr_gen u_rma_addr_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .seg(seg), .off(off),
    .gate_en(gate_en), .bus_addr(bus_addr), .addr_valid(addr_valid));

  // expected address: sixteen times the segment plus offset, line 20 cleared if closed
  function automatic logic [23:0] expect_addr(input logic [15:0] s, input logic [15:0] o,
                                              input logic g);
    int unsigned v;
    v = int'(s) * 16 + int'(o);
    if (!g) v = v & ~(32'd1 << 20);
    return v[23:0];
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // one strobe; returns at the negedge after the capture edge
  task automatic strobe(input logic [15:0] s, input logic [15:0] o, input logic g);
    @(negedge clk);
    seg = s; off = o; gate_en = g; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 addr after reset", bus_addr, 24'h0);
    check("R1 valid after reset", {23'b0, addr_valid}, 24'h0);
  endtask

  task automatic t_pair(input string tag, input logic [15:0] s, input logic [15:0] o,
                        input logic g);
    strobe(s, o, g);
    check({tag, " addr"}, bus_addr, expect_addr(s, o, g));
    check("R2 valid pulse", {23'b0, addr_valid}, 24'h1);
    check("R5 upper lines", {21'b0, bus_addr[23:21]}, 24'h0);
    @(negedge clk);
    check("R2 valid drops", {23'b0, addr_valid}, 24'h0);
  endtask

  task automatic t_hold;
    logic [23:0] held;
    strobe(16'hFFFF, 16'h0010, 1'b1);
    held = bus_addr;
    // R7: gate flips right after the capture edge
    gate_en = 1'b0;
    @(negedge clk);
    check("R7 gate change after strobe", bus_addr, 24'h100000);
    seg = 16'h1234; off = 16'h5678; gate_en = 1'b1;
    @(negedge clk);
    seg = 16'h0000; off = 16'hFFFF; gate_en = 1'b0;
    @(negedge clk);
    check("R6 hold while idle", bus_addr, held);
    check("R6 valid low while idle", {23'b0, addr_valid}, 24'h0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    seg = 16'hFFFF; off = 16'hFFFF; gate_en = 1'b1; req = 1'b1;
    @(negedge clk);
    check("R3 first of pair", bus_addr, 24'h10FFEF);
    gate_en = 1'b0;
    @(negedge clk);
    req = 1'b0;
    check("R4 second of pair", bus_addr, 24'h00FFEF);
    check("R2 valid held on consecutive strobes", {23'b0, addr_valid}, 24'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R8: below 1 MB, both gate states
    t_pair("R8 1234:0005 closed", 16'h1234, 16'h0005, 1'b0);
    t_pair("R8 1234:0005 open", 16'h1234, 16'h0005, 1'b1);
    t_pair("R8 FFFF:000F closed", 16'hFFFF, 16'h000F, 1'b0);
    t_pair("R8 FFFF:000F open", 16'hFFFF, 16'h000F, 1'b1);
    check("R8 top byte value", bus_addr, 24'h0FFFFF);
    // R4: carry masked
    t_pair("R4 FFFF:0010 closed", 16'hFFFF, 16'h0010, 1'b0);
    t_pair("R4 FFFF:FFFF closed", 16'hFFFF, 16'hFFFF, 1'b0);
    t_pair("R4 F800:8000 closed", 16'hF800, 16'h8000, 1'b0);
    // R3: carry passed
    t_pair("R3 FFFF:0010 open", 16'hFFFF, 16'h0010, 1'b1);
    t_pair("R3 FFFF:FFFF open", 16'hFFFF, 16'hFFFF, 1'b1);
    t_pair("R3 F800:8000 open", 16'hF800, 16'h8000, 1'b1);
    t_hold();
    t_back_to_back();
    // reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule